// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block holds the configuration state of a four-bank SDRAM controller behind two bus registers. Software first writes an internal register offset into the address port and then reads or writes the data port, which reaches the register selected by that offset. The register set covers two error-status words, an error address, a global configuration word, a read-only status word, refresh, power-management and timing words, four bank descriptors, an ECC configuration word and an ECC error word. Each register has its own write mask or forced bits, and some writes have side effects.

Each bank descriptor gives a base address and a power-of-two size. The global enable bit in the configuration word gates all of the bank mappings. A physical probe address is decoded against the enabled banks and returns a hit flag and a bank index. A nonzero ECC error word drives an interrupt output.

Top module: `sdram_cfg_regs`

## Requirements
- R1: With `sel_data`=0, writes load the address port and reads return it. With `sel_data`=1, accesses reach the register at that offset: 0x00/0x08 error status, 0x10 error address, 0x20 config, 0x24 status, 0x30 refresh, 0x34 power management, 0x40/0x44/0x48/0x4C banks 0-3, 0x80 timing, 0x94 ECC config, 0x98 ECC error. Any other offset reads 0.
- R2: Both error-status registers are write-one-to-clear: the new value is the old value AND NOT the written data.
- R3: A config write that takes bit 31 from 0 to 1 clears status bit 31. A write that takes it from 1 to 0 sets status bit 31.
- R4: Status bit 30 is set when config bit 30 rises and cleared when it falls. Writes to the status register have no effect.
- R5: Refresh stores data AND 0x3FF80000. Timing stores data AND 0x018FC01F. ECC config stores data AND 0x00F00000. Power management stores (data AND 0xF8000000) OR 0x07C00000.
- R6: A bank write stores data AND 0xFFDEE001. Bits 31:23 are the base, bits 19:17 are a shift n with size = 4 MiB << n, and bit 0 is the bank enable.
- R7: A bank matches a probe address when its enable bit and config bit 31 are both set and the probe masked to the bank size equals the base masked the same way. `hit` is 1 when any bank matches.
- R8: When more than one bank matches, `hit_bank` gives the lowest-numbered matching bank.
- R9: `ecc_irq` rises when the ECC error register goes from zero to nonzero and falls when the register returns to zero.
- R10: After reset the registers hold: address 0, error address 0, both error-status 0, ECC config 0, ECC error 0, power management 0x07C00000, refresh 0x05F00000, timing 0x00854009, status 0, config 0x00800000, and all banks 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_data | input | 1 | 0 selects the address port, 1 selects the data port |
| wr_en | input | 1 | Write strobe for the selected port |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected port (combinational) |
| probe_addr | input | 32 | Physical address to decode |
| hit | output | 1 | Probe falls in an enabled bank |
| hit_bank | output | 2 | Index of the matching bank |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
The assertions assume that `wr_en` is never X while out of reset and that `wdata` is stable through the edge at which it is sampled. The bench drives every input on the falling edge and holds it for a full cycle. Reads are taken combinationally half a cycle after the last write. Bank sizes and probe addresses are kept to aligned values so that every expected hit can be worked out by hand.

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_data,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [31:0] probe_addr,
  output logic        hit,
  output logic [1:0]  hit_bank,
  output logic        ecc_irq
);
  localparam int NBANK = 4;

  logic [31:0] addr_q, err0_q, err1_q, eaddr_q, cfg_q, stat_q;
  logic [31:0] rtr_q, pm_q, tim_q, ecfg_q, eerr_q;
  logic [31:0] bank_q [NBANK];
  logic [31:0] dsel;
  logic        dwr;

  assign dwr = wr_en && sel_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      err0_q  <= '0;
      err1_q  <= '0;
      eaddr_q <= '0;
      cfg_q   <= 32'h0080_0000;
      stat_q  <= '0;
      rtr_q   <= 32'h05F0_0000;
      pm_q    <= 32'h07C0_0000;
      tim_q   <= 32'h0085_4009;
      ecfg_q  <= '0;
      eerr_q  <= '0;
      for (int i = 0; i < NBANK; i++) bank_q[i] <= '0;
    end else if (wr_en && !sel_data) begin
      addr_q <= wdata;
    end else if (dwr) begin
      case (addr_q)
        32'h00: err0_q  <= err0_q & ~wdata;
        32'h08: err1_q  <= err1_q & ~wdata;
        32'h10: eaddr_q <= wdata;
        32'h20: begin
          cfg_q <= wdata;
          if (!cfg_q[31] && wdata[31]) stat_q[31] <= 1'b0;
          else if (cfg_q[31] && !wdata[31]) stat_q[31] <= 1'b1;
          if (!cfg_q[30] && wdata[30]) stat_q[30] <= 1'b1;
          else if (cfg_q[30] && !wdata[30]) stat_q[30] <= 1'b0;
        end
        32'h30: rtr_q  <= wdata & 32'h3FF8_0000;
        32'h34: pm_q   <= (wdata & 32'hF800_0000) | 32'h07C0_0000;
        32'h80: tim_q  <= wdata & 32'h018F_C01F;
        32'h94: ecfg_q <= wdata & 32'h00F0_0000;
        32'h98: eerr_q <= wdata;
        default: begin
          for (int i = 0; i < NBANK; i++)
            if (addr_q == 32'h40 + 32'(4 * i)) bank_q[i] <= wdata & 32'hFFDE_E001;
        end
      endcase
    end
  end

  always_comb begin
    case (addr_q)
      32'h00: dsel = err0_q;
      32'h08: dsel = err1_q;
      32'h10: dsel = eaddr_q;
      32'h20: dsel = cfg_q;
      32'h24: dsel = stat_q;
      32'h30: dsel = rtr_q;
      32'h34: dsel = pm_q;
      32'h40: dsel = bank_q[0];
      32'h44: dsel = bank_q[1];
      32'h48: dsel = bank_q[2];
      32'h4C: dsel = bank_q[3];
      32'h80: dsel = tim_q;
      32'h94: dsel = ecfg_q;
      32'h98: dsel = eerr_q;
      default: dsel = '0;
    endcase
  end

  assign rdata   = sel_data ? dsel : addr_q;
  assign ecc_irq = |eerr_q;

  always_comb begin
    logic [31:0] msk;
    hit      = 1'b0;
    hit_bank = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      msk = ~((32'h0040_0000 << bank_q[i][19:17]) - 32'h1);
      if (cfg_q[31] && bank_q[i][0] &&
          ((probe_addr & msk) == (bank_q[i] & 32'hFF80_0000 & msk))) begin
        hit      = 1'b1;
        hit_bank = 2'(i);
      end
    end
  end

  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && addr_q == 32'h00) |=> ((err0_q & $past(wdata)) == 32'h0));
  p_en_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && addr_q == 32'h20 && !cfg_q[31] && wdata[31]) |=> !stat_q[31]);
  p_en_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && addr_q == 32'h20 && cfg_q[31] && !wdata[31]) |=> stat_q[31]);
  p_stat_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && addr_q == 32'h24) |=> $stable(stat_q));
  p_pm_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pm_q[26:22] == 5'h1F);
  p_hit_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (cfg_q[31] && bank_q[hit_bank][0]));
  p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && addr_q == 32'h98 && wdata != 32'h0) |=> ecc_irq);
  p_irq_lower_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && addr_q == 32'h98 && wdata == 32'h0) |=> !ecc_irq);
endmodule

// File: tb/sdram_cfg_regs_tb_top.sv
module sdram_cfg_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_data = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] probe_addr = '0;
  logic        hit;
  logic [1:0]  hit_bank;
  logic        ecc_irq;
  int          nchk = 0;
  int          nerr = 0;

  always #4 clk = ~clk;

  sdram_cfg_regs dut_i (
    .clk(clk), .rst_n(rst_n), .sel_data(sel_data), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .probe_addr(probe_addr),
    .hit(hit), .hit_bank(hit_bank), .ecc_irq(ecc_irq)
  );

  // offset, write data, expected readback
  localparam logic [95:0] VEC [10] = '{
    {32'h30, 32'hFFFF_FFFF, 32'h3FF8_0000},
    {32'h34, 32'h0000_0000, 32'h07C0_0000},
    {32'h34, 32'hFFFF_FFFF, 32'hFFC0_0000},
    {32'h80, 32'hFFFF_FFFF, 32'h018F_C01F},
    {32'h94, 32'hFFFF_FFFF, 32'h00F0_0000},
    {32'h48, 32'hFFFF_FFFF, 32'hFFDE_E001},
    {32'h10, 32'h1234_5678, 32'h1234_5678},
    {32'h24, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h60, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h08, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic put(input logic s, input logic [31:0] d);
    @(negedge clk);
    sel_data = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wreg(input logic [31:0] off, input logic [31:0] d);
    put(1'b0, off);
    put(1'b1, d);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rreg(input string tag, input logic [31:0] off, input logic [31:0] exp);
    put(1'b0, off);
    sel_data = 1'b1;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic h, input logic [1:0] b);
    probe_addr = a;
    #1;
    chk(tag, {30'b0, hit}, {31'b0, h});
    if (h) chk(tag, {30'b0, hit_bank}, {30'b0, b});
  endtask

  initial begin
    #400000;
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset values
    sel_data = 1'b0; #1 chk("R10 addr", rdata, 32'h0);
    rreg("R10 err0", 32'h00, 32'h0);
    rreg("R10 eaddr", 32'h10, 32'h0);
    rreg("R10 cfg", 32'h20, 32'h0080_0000);
    rreg("R10 stat", 32'h24, 32'h0);
    rreg("R10 rtr", 32'h30, 32'h05F0_0000);
    rreg("R10 pm", 32'h34, 32'h07C0_0000);
    rreg("R10 tim", 32'h80, 32'h0085_4009);
    rreg("R10 ecfg", 32'h94, 32'h0);
    rreg("R10 eerr", 32'h98, 32'h0);
    rreg("R10 bank3", 32'h4C, 32'h0);
    chk("R10 irq", {31'b0, ecc_irq}, 32'h0);
    // R1 address port readback
    put(1'b0, 32'h0000_0094);
    sel_data = 1'b0; #1 chk("R1 addr readback", rdata, 32'h94);
    // R1 R2 R4 R5 R6 vector walk
    for (int i = 0; i < 10; i++) begin
      wreg(VEC[i][95:64], VEC[i][63:32]);
      sel_data = 1'b1;
      #1 chk($sformatf("R5/R6/R1/R2/R4 vec%0d", i), rdata, VEC[i][31:0]);
    end
    wreg(32'h48, 32'h0);
    // R3 R7 bank decode
    wreg(32'h40, 32'h1002_0001);
    probe("R7 global off", 32'h1010_0000, 1'b0, 2'd0);
    wreg(32'h20, 32'h8000_0000);
    rreg("R3 rise stat", 32'h24, 32'h0);
    probe("R7 in bank0", 32'h1070_0000, 1'b1, 2'd0);
    probe("R7 above bank0", 32'h1080_0000, 1'b0, 2'd0);
    wreg(32'h44, 32'h1004_0001);
    probe("R7 bank1 size", 32'h1080_0000, 1'b1, 2'd1);
    probe("R8 priority", 32'h1010_0000, 1'b1, 2'd0);
    wreg(32'h48, 32'h2000_0000);
    probe("R7 bank disabled", 32'h2000_0000, 1'b0, 2'd0);
    wreg(32'h4C, 32'h1000_0001);
    probe("R8 bank3 lower priority", 32'h1000_0000, 1'b1, 2'd0);
    wreg(32'h20, 32'h0);
    rreg("R3 fall stat", 32'h24, 32'h8000_0000);
    probe("R7 global cleared", 32'h1000_0000, 1'b0, 2'd0);
    // R4 status bit 30
    wreg(32'h20, 32'h4000_0000);
    rreg("R4 rise", 32'h24, 32'hC000_0000);
    wreg(32'h20, 32'h0);
    rreg("R4 fall", 32'h24, 32'h8000_0000);
    wreg(32'h24, 32'h0);
    rreg("R4 ignored", 32'h24, 32'h8000_0000);
    // R9 ECC interrupt
    wreg(32'h98, 32'h5);
    #1 chk("R9 raise", {31'b0, ecc_irq}, 32'h1);
    wreg(32'h98, 32'h3);
    #1 chk("R9 hold", {31'b0, ecc_irq}, 32'h1);
    wreg(32'h98, 32'h0);
    #1 chk("R9 lower", {31'b0, ecc_irq}, 32'h0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule